// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

A 16-bit up-counter held as a low and a high byte. It counts either a divided internal clock or rising edges of an external clock input. A prescaler divides the chosen source by 1, 2, 4 or 8. A gate can qualify counting: the gate comes from an external gate pin or from a comparator output, and its polarity can be inverted. When the count wraps from all ones to zero, a sticky overflow flag is raised.

Software reaches the block through a byte-wide register port with four addresses. The control byte selects the source, the prescale ratio, the gate behaviour and whether the external clock is synchronized. The two count bytes can be read and overwritten at any time. The status byte holds the overflow flag.

The whole block runs in the system clock domain. The external clock is sampled there, either through a two-flop synchronizer or directly from the pin.

Top module: `gated_count_timer`

## Requirements
- R1: After reset, every readable register (control at address 0, count low at 1, count high at 2, status at 3) reads 0, and the overflow flag output is low.
- R2: A write to address 1 or 2 replaces that byte of the count at the write edge. A byte write takes precedence over an increment in the same cycle.
- R3: Control bit 1 = 0 selects the internal source, which gives one tick per 4 enabled system clocks. Control bits 4:3 select a prescale ratio of 1, 2, 4 or 8 (codes 0 to 3). After a count write, the count therefore advances by 1 every 4×ratio enabled cycles.
- R4: With control bit 0 (run) clear, the count does not change.
- R5: Control bit 1 = 1 with control bit 2 = 0 counts rising edges of the external clock through a two-flop synchronizer. Each edge gives exactly one tick, and the count changes on the third clock edge after the input rises.
- R6: Control bit 2 = 1 bypasses the synchronizer. A rising external edge is counted on the first clock edge after it, and an input held high counts only once.
- R7: Control bit 5 enables the gate, and counting then needs the gate to be active. Bit 6 selects the source: 0 for the gate pin, 1 for the comparator input. Bit 7 inverts the gate: when it is clear the gate is active high, and when it is set the gate is active low. The unselected source has no effect.
- R8: With control bit 5 clear, the gate inputs and the invert bit have no effect on counting.
- R9: An increment from 0xFFFF wraps the count to 0x0000 and sets the overflow flag (status bit 0, and the flag output).
- R10: The overflow flag stays set until status bit 0 is written with 0. Writing 1 to that bit has no effect. When an overflow and a clearing write happen in the same cycle, the flag ends set.
- R11: A count-byte write clears the prescaler and the internal divide-by-4 phase. A control write that changes bits 4:3 clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| ext_clk_i | input | 1 | External count clock |
| gate_pin_i | input | 1 | External gate pin |
| cmp_out_i | input | 1 | Comparator output used as gate |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
A vector table runs the internal source at each of the four prescale ratios, with the gate pin and the comparator driven high and low under every gate setting. This separates the ratio decode, the source selection, the inversion and the ignoring of the unselected source. Directed tests step the external clock in both sampling modes, which tells them apart by the two-edge difference in latency. They also place a clearing write on the exact overflow edge and disturb the prescaler partway through a period, so that a missing prescaler clear shows up as an increment at the wrong cycle.

// File: rtl/gct_pkg.sv
package gct_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CLO  = 2'd1;
  localparam logic [1:0] ADDR_CHI  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic       gate_inv;
    logic       gate_sel;
    logic       gate_en;
    logic [1:0] psel;
    logic       ext_async;
    logic       ext_src;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/gct_src_sel.sv
module gct_src_sel #(
  parameter int INT_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic ext_src_i,
  input  logic ext_async_i,
  input  logic gate_en_i,
  input  logic gate_sel_i,
  input  logic gate_inv_i,
  input  logic gate_pin_i,
  input  logic cmp_out_i,
  input  logic ext_clk_i,
  input  logic div_clr_i,
  output logic tick_o
);
  localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

  logic gate_ok, en, int_tick, sync_edge, async_edge;
  logic [SYNC_STAGES:0] sh_q;

  assign gate_ok = !gate_en_i || ((gate_sel_i ? cmp_out_i : gate_pin_i) ^ gate_inv_i);
  assign en      = run_i && gate_ok;

  generate
    if (INT_DIV > 1) begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        div_q <= '0;
        else if (div_clr_i) div_q <= '0;
        else if (en)        div_q <= (div_q == DIV_W'(INT_DIV - 1)) ? '0 : div_q + 1'b1;
      end
      assign int_tick = en && (div_q == DIV_W'(INT_DIV - 1));
    end else begin : g_nodiv
      assign int_tick = en;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign sync_edge  = sh_q[SYNC_STAGES-1] && !sh_q[SYNC_STAGES];
  assign async_edge = ext_clk_i && !sh_q[0];  // raw pin, one-register edge compare

  assign tick_o = ext_src_i ? (en && (ext_async_i ? async_edge : sync_edge)) : int_tick;
endmodule

// File: rtl/gct_prescale.sv
module gct_prescale #(
  parameter int PS_BITS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clr_i,
  input  logic [PS_BITS-1:0] psel_i,
  output logic               pulse_o
);
  localparam int PC_W = (1 << PS_BITS) - 1;

  logic [PC_W-1:0] ps_q, lim;

  assign lim     = ~({PC_W{1'b1}} << psel_i);
  assign pulse_o = tick_i && (ps_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ps_q <= '0;
    else if (clr_i)   ps_q <= '0;
    else if (pulse_o) ps_q <= '0;
    else if (tick_i)  ps_q <= ps_q + 1'b1;
  end
endmodule

// File: rtl/gct_count.sv
module gct_count #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              flag_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_o
);
  logic ovf;

  assign ovf = inc_i && !wr_lo_i && !wr_hi_i && (&cnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_o[DATA_W-1:0]     <= wdata_i;
      if (wr_hi_i) cnt_o[CNT_W-1:DATA_W] <= wdata_i;
    end else if (inc_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (ovf)        flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/gated_count_timer.sv
module gated_count_timer
  import gct_pkg::*;
#(
  parameter int INT_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ext_clk_i,
  input  logic              gate_pin_i,
  input  logic              cmp_out_i,
  output logic              ovf_flag_o
);
  ctrl_t            ctrl_q, ctrl_new;
  logic             wr_ctrl, wr_lo, wr_hi, wr_stat;
  logic             psel_chg, cnt_wr, run_w, tick, inc;
  logic [CNT_W-1:0] cnt;

  assign wr_ctrl  = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_lo    = wr_en_i && (addr_i == ADDR_CLO);
  assign wr_hi    = wr_en_i && (addr_i == ADDR_CHI);
  assign wr_stat  = wr_en_i && (addr_i == ADDR_STAT);
  assign ctrl_new = ctrl_t'(wdata_i);
  assign psel_chg = wr_ctrl && (ctrl_new.psel != ctrl_q.psel);
  assign cnt_wr   = wr_lo || wr_hi;
  assign run_w    = ctrl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_new;
  end

  gct_src_sel #(
    .INT_DIV    (INT_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_w),
    .ext_src_i  (ctrl_q.ext_src),
    .ext_async_i(ctrl_q.ext_async),
    .gate_en_i  (ctrl_q.gate_en),
    .gate_sel_i (ctrl_q.gate_sel),
    .gate_inv_i (ctrl_q.gate_inv),
    .gate_pin_i (gate_pin_i),
    .cmp_out_i  (cmp_out_i),
    .ext_clk_i  (ext_clk_i),
    .div_clr_i  (cnt_wr),
    .tick_o     (tick)
  );

  gct_prescale #(.PS_BITS(2)) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clr_i  (cnt_wr || psel_chg),
    .psel_i (ctrl_q.psel),
    .pulse_o(inc)
  );

  gct_count #(.DATA_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .wdata_i   (wdata_i),
    .flag_clr_i(wr_stat && !wdata_i[0]),
    .cnt_o     (cnt),
    .flag_o    (ovf_flag_o)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_CLO:  rdata_o = cnt[DATA_W-1:0];
      ADDR_CHI:  rdata_o = cnt[CNT_W-1:DATA_W];
      default:   rdata_o = {{(DATA_W-1){1'b0}}, ovf_flag_o};
    endcase
  end
endmodule

// File: rtl/gated_count_timer_chk.sv
module gated_count_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic        run_i,
  input logic [15:0] cnt_i,
  input logic        flag_i
);
  logic cnt_wr, flag_clr;
  assign cnt_wr   = wr_en_i && (addr_i == 2'd1 || addr_i == 2'd2);
  assign flag_clr = wr_en_i && (addr_i == 2'd3) && !wdata_i[0];

  a_r2_low_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=> cnt_i[7:0] == $past(wdata_i));

  a_r2_high_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> cnt_i[15:8] == $past(wdata_i));

  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr |=> (cnt_i == $past(cnt_i) || cnt_i == 16'($past(cnt_i) + 16'd1)));

  a_r4_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr) |=> $stable(cnt_i));

  a_r9_wrap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr && cnt_i == 16'hFFFF) ##1 (cnt_i == 16'h0000) |-> flag_i);

  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !flag_clr) |=> flag_i);

  a_r10_rise_from_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> ($past(cnt_i) == 16'hFFFF && cnt_i == 16'h0000));
endmodule

bind gated_count_timer gated_count_timer_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .run_i  (run_w),
  .cnt_i  (cnt),
  .flag_i (ovf_flag_o)
);

// File: tb/gated_count_timer_tb.sv
module gated_count_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       ext_clk_i = 1'b0;
  logic       gate_pin_i = 1'b0;
  logic       cmp_out_i = 1'b0;
  logic       ovf_flag_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  gated_count_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ext_clk_i(ext_clk_i),
    .gate_pin_i(gate_pin_i), .cmp_out_i(cmp_out_i), .ovf_flag_o(ovf_flag_o)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic        pin;
    logic        cmp;
    logic [15:0] start;
    logic [7:0]  n;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{8'h01, 1'b0, 1'b0, 16'h0100, 8'd40, 16'h010A},  // R3 ratio 1
    '{8'h09, 1'b0, 1'b0, 16'h0100, 8'd40, 16'h0105},  // R3 ratio 2
    '{8'h11, 1'b0, 1'b0, 16'h0100, 8'd40, 16'h0102},  // R3 ratio 4
    '{8'h19, 1'b0, 1'b0, 16'h0100, 8'd64, 16'h0102},  // R3 ratio 8
    '{8'h00, 1'b1, 1'b1, 16'h0100, 8'd40, 16'h0100},  // R4 run off
    '{8'h21, 1'b1, 1'b0, 16'h0100, 8'd40, 16'h010A},  // R7 pin high
    '{8'h21, 1'b0, 1'b1, 16'h0100, 8'd40, 16'h0100},  // R7 pin low, cmp ignored
    '{8'hA1, 1'b0, 1'b0, 16'h0100, 8'd40, 16'h010A},  // R7 inverted, pin low
    '{8'hA1, 1'b1, 1'b0, 16'h0100, 8'd40, 16'h0100},  // R7 inverted, pin high
    '{8'h61, 1'b0, 1'b1, 16'h0100, 8'd40, 16'h010A},  // R7 cmp high
    '{8'h61, 1'b1, 1'b0, 16'h0100, 8'd40, 16'h0100},  // R7 cmp low, pin ignored
    '{8'h01, 1'b0, 1'b0, 16'h0100, 8'd40, 16'h010A},  // R8 gate off, inputs low
    '{8'h81, 1'b1, 1'b1, 16'h0100, 8'd40, 16'h010A},  // R8 gate off, invert set
    '{8'h01, 1'b0, 1'b0, 16'hFFF8, 8'd40, 16'h0002}   // R9 wrap
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic rd_cnt(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic load(input logic [15:0] v);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;

    // R1 reset state
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(2'd0, b); chk("R1 ctrl", {8'h0, b}, 16'h0);
    rd_cnt(v);   chk("R1 count", v, 16'h0);
    rd(2'd3, b); chk("R1 status", {8'h0, b}, 16'h0);
    chk("R1 flag pin", {15'h0, ovf_flag_o}, 16'h0);

    // R2 byte loads
    load(16'h1234);
    rd_cnt(v); chk("R2 load", v, 16'h1234);
    wr(2'd2, 8'hAB);
    rd_cnt(v); chk("R2 high only", v, 16'hAB34);

    // table walk
    for (int i = 0; i < NV; i++) begin
      gate_pin_i = TBL[i].pin;
      cmp_out_i  = TBL[i].cmp;
      wr(2'd0, TBL[i].ctrl);
      load(TBL[i].start);
      wait_n(int'(TBL[i].n));
      rd_cnt(v);
      chk($sformatf("R3/R4/R7/R8/R9 vector %0d", i), v, TBL[i].exp);
    end
    chk("R9 flag after wrap", {15'h0, ovf_flag_o}, 16'h1);
    gate_pin_i = 1'b0; cmp_out_i = 1'b0;

    // R10 sticky flag
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h01);
    rd(2'd3, b); chk("R10 write 1 keeps flag", {8'h0, b}, 16'h1);
    wr(2'd3, 8'h00);
    rd(2'd3, b); chk("R10 write 0 clears", {8'h0, b}, 16'h0);

    // R9 exact overflow edge
    wr(2'd0, 8'h01);
    load(16'hFFFE);
    wait_n(7);
    rd_cnt(v); chk("R9 before wrap", v, 16'hFFFF);
    chk("R9 flag low before wrap", {15'h0, ovf_flag_o}, 16'h0);
    wait_n(1);
    rd_cnt(v); chk("R9 wrapped", v, 16'h0000);
    chk("R9 flag set", {15'h0, ovf_flag_o}, 16'h1);
    wr(2'd3, 8'h00);

    // R10 set wins over clear in same cycle
    load(16'hFFFF);
    wait_n(3);
    wr(2'd3, 8'h00);
    chk("R10 set beats clear", {15'h0, ovf_flag_o}, 16'h1);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);

    // R11 count write clears prescaler
    wr(2'd0, 8'h19);
    load(16'h0000);
    wait_n(20);
    wr(2'd1, 8'h00);
    wait_n(31);
    rd_cnt(v); chk("R11 count write restarts prescaler", v, 16'h0000);
    wait_n(1);
    rd_cnt(v); chk("R11 first step after restart", v, 16'h0001);

    // R11 prescale change clears prescaler
    load(16'h0000);
    wait_n(20);
    wr(2'd0, 8'h11);
    wait_n(14);
    rd_cnt(v); chk("R11 psel change, before step", v, 16'h0000);
    wait_n(1);
    rd_cnt(v); chk("R11 psel change, step", v, 16'h0001);

    // R5 synchronized external clock
    wr(2'd0, 8'h03);
    load(16'h0000);
    ext_clk_i = 1'b1;
    wait_n(2);
    rd_cnt(v); chk("R5 not yet counted", v, 16'h0000);
    wait_n(1);
    rd_cnt(v); chk("R5 counted on third edge", v, 16'h0001);
    wait_n(8);
    rd_cnt(v); chk("R5 held high counts once", v, 16'h0001);
    ext_clk_i = 1'b0;
    wait_n(4);
    ext_clk_i = 1'b1;
    wait_n(3);
    rd_cnt(v); chk("R5 second edge", v, 16'h0002);
    ext_clk_i = 1'b0;

    // R6 unsynchronized external clock
    wr(2'd0, 8'h07);
    load(16'h0000);
    ext_clk_i = 1'b1;
    wait_n(1);
    rd_cnt(v); chk("R6 counted on first edge", v, 16'h0001);
    wait_n(5);
    rd_cnt(v); chk("R6 held high counts once", v, 16'h0001);
    ext_clk_i = 1'b0;
    wait_n(2);
    ext_clk_i = 1'b1;
    wait_n(1);
    rd_cnt(v); chk("R6 second edge", v, 16'h0002);
    ext_clk_i = 1'b0;

    // R3 prescale on external source: ratio 2
    wr(2'd0, 8'h0F);
    load(16'h0000);
    for (int k = 0; k < 4; k++) begin
      ext_clk_i = 1'b1; wait_n(2);
      ext_clk_i = 1'b0; wait_n(2);
    end
    rd_cnt(v); chk("R3 ext ratio 2", v, 16'h0002);

    // R4 external edges ignored when run is off
    wr(2'd0, 8'h06);
    ext_clk_i = 1'b1; wait_n(4);
    ext_clk_i = 1'b0; wait_n(2);
    rd_cnt(v); chk("R4 ext ignored when off", v, 16'h0002);

    done = 1'b1;
    finish_run();
  end
endmodule